// File: doc/BRIEF.md
# DMA Block Transfer Address and Count Engine

This engine runs one block transfer for a single DMA channel whose registers have already been programmed. At a start request it takes a snapshot of the channel's current and base address and count, its two page bytes and its auto-initialise setting. It also captures three byte quantities from the device: how many bytes it can supply, the offset where the transfer starts in its buffer, and the size of that buffer. From these it works out the physical memory address and how many units to move. It then issues one memory beat per unit, each held until the memory side signals ready.

When a block ends, the engine reports the new current address and count through a one-cycle register-write strobe, and the register file outside the engine applies them. A complete block on an auto-initialise channel writes back the base values instead. If the device still has bytes left over, another block starts from those reloaded values. A block that would run past the end of the device buffer is refused: the error flag is raised and nothing is written. A start request on a masked channel is dropped.

Channels at or above a parameterised threshold (channels 5 to 7 by default) move 16-bit units. On those channels the address is shifted left by one and each unit counts as two bytes. All other channels move single bytes.

Top module: `dma_xfer_engine`

## Requirements
- R1: Each beat drives `mem_addr_o` as {high page[7:0], page[7:0], A[15:0]}. A is the running current address modulo 2^16 on byte channels. On word channels (channel >= 5), A is that address shifted left by one and cut to 16 bits. The running address starts at the current address and rises by one per beat.
- R2: A block's programmed length is (current count + 1) mod 2^16 units, with 0 meaning 65536. A unit is 2 bytes on word channels and 1 byte on the others. When enough bytes are available, exactly that many beats are issued.
- R3: When the available byte count is below the programmed length in bytes, the block moves floor(available / unit size) units, which may be zero. Such a short block never reloads from the base values, even with auto-initialise set.
- R4: At the end of each block, `reg_wr_o` pulses for one cycle. With it come the channel, the current address plus the units moved, and the current count minus the units moved, both modulo 2^16. A complete block without reload therefore writes count 0xFFFF.
- R5: A complete block with `autoinit_i` set writes back the base address and base count instead.
- R6: With `autoinit_i` set and more bytes available than a complete block uses, a further block starts from the base values. Its available count is reduced by the bytes already moved and its offset is advanced by them. This repeats until the condition fails.
- R7: If a block's offset plus its byte length exceeds the buffer size, `err_o` pulses for one cycle and the transfer ends. That block issues no beats, no register write and no done.
- R8: While `mem_req_o` is high and `mem_ready_i` is low, the request stays high and `mem_addr_o` holds its value. A beat completes only on a cycle with both high.
- R9: `done_o` pulses for exactly one cycle, together with the final register write. When the final block had beats, that cycle directly follows the last beat.
- R10: A start request with `masked_i` high produces no beat, no register write, no done, no error, and `busy_o` stays low.
- R11: After reset the engine is idle with every output strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured while idle |
| start_ch_i | input | CH_W | Channel of the request |
| masked_i | input | 1 | Channel is masked; request is dropped |
| autoinit_i | input | 1 | Auto-initialise enabled for the channel |
| cur_addr_i | input | 16 | Current address register |
| cur_cnt_i | input | 16 | Current count register |
| base_addr_i | input | 16 | Base address register |
| base_cnt_i | input | 16 | Base count register |
| page_i | input | 8 | Page byte, physical bits 23:16 |
| page_hi_i | input | 8 | High page byte, physical bits 31:24 |
| avail_i | input | AVAIL_W | Bytes the device can supply |
| offset_i | input | AVAIL_W | Start offset in the device buffer |
| bufsize_i | input | AVAIL_W | Device buffer size in bytes |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_req_o | output | 1 | Beat request |
| mem_addr_o | output | 32 | Physical byte address of the beat |
| mem_word_o | output | 1 | Beat is a 2-byte unit |
| reg_wr_o | output | 1 | Register write-back strobe |
| reg_ch_o | output | CH_W | Channel being written back |
| reg_addr_o | output | 16 | New current address |
| reg_cnt_o | output | 16 | New current count |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | Transfer refused, out of buffer bounds |
| busy_o | output | 1 | Engine not idle |

## Verification
The assertions assume three things about the inputs. `start_i` is only raised while `busy_o` is low. The register and device inputs sampled at start stay meaningful for that one request. `mem_ready_i` is free to stall for any number of cycles. The bench keeps to this by sending each request only after the previous one has ended with done or error, or after a fixed idle gap for masked requests. It drives ready either always high or in a stalling pattern that repeats every three cycles. Offsets and sizes stay well inside the available-byte width, so the offset and byte sums never wrap.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int REG_W  = 16;
  localparam int PAGE_W = 8;
  localparam int PHYS_W = REG_W + 2 * PAGE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_BEAT,
    ST_WBACK
  } eng_state_t;

  // Physical byte address of one unit: pages on top, the 16-bit
  // channel address below, doubled for word channels.
  function automatic logic [PHYS_W-1:0] phys_addr(
    input logic              word,
    input logic [REG_W-1:0]  a,
    input logic [PAGE_W-1:0] pg,
    input logic [PAGE_W-1:0] hi
  );
    logic [REG_W-1:0] lo;
    lo = word ? {a[REG_W-2:0], 1'b0} : a;
    return {hi, pg, lo};
  endfunction

  // Register value moved by a signed number of units, modulo 2^REG_W.
  function automatic logic [REG_W-1:0] reg_step(
    input logic [REG_W-1:0] v,
    input logic [REG_W-1:0] n,
    input logic             up
  );
    return up ? v + n : v - n;
  endfunction

endpackage

// File: rtl/dma_blk_plan.sv
module dma_blk_plan #(
  parameter int REG_W   = 16,
  parameter int AVAIL_W = 20,
  localparam int UW     = REG_W + 1,
  localparam int BW     = AVAIL_W + 2
) (
  input  logic               word_i,
  input  logic [REG_W-1:0]   cnt_i,
  input  logic [AVAIL_W-1:0] avail_i,
  input  logic [AVAIL_W-1:0] offset_i,
  input  logic [AVAIL_W-1:0] bufsize_i,
  output logic [UW-1:0]      units_o,
  output logic [AVAIL_W-1:0] bytes_o,
  output logic               short_o,
  output logic               more_o,
  output logic               oob_o
);

  logic [BW-1:0] prog_units, prog_bytes, avail_w, fit_units, units_w, bytes_w;

  always_comb begin
    prog_units = BW'(cnt_i) + BW'(1);
    prog_bytes = word_i ? (prog_units << 1) : prog_units;
    avail_w    = BW'(avail_i);
    fit_units  = word_i ? (avail_w >> 1) : avail_w;
    short_o    = avail_w < prog_bytes;
    more_o     = avail_w > prog_bytes;
    units_w    = short_o ? fit_units : prog_units;
    bytes_w    = word_i ? (units_w << 1) : units_w;
    oob_o      = (BW'(offset_i) + bytes_w) > BW'(bufsize_i);
    units_o    = units_w[UW-1:0];
    bytes_o    = bytes_w[AVAIL_W-1:0];
  end

endmodule

// File: rtl/dma_beat_gen.sv
module dma_beat_gen #(
  parameter int AW = 16,
  parameter int UW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [UW-1:0] load_units_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  logic [AW-1:0] run_addr_q;
  logic [UW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_addr_q <= '0;
      left_q     <= '0;
    end else if (load_i) begin
      run_addr_q <= load_addr_i;
      left_q     <= load_units_i;
    end else if (adv_i) begin
      run_addr_q <= run_addr_q + AW'(1);
      left_q     <= left_q - UW'(1);
    end
  end

  assign addr_o = run_addr_q;
  assign last_o = (left_q == UW'(1));

endmodule

// File: rtl/dma_wback.sv
module dma_wback
  import dma_xfer_pkg::*;
#(
  parameter int UW = REG_W + 1
) (
  input  logic [REG_W-1:0] cur_addr_i,
  input  logic [REG_W-1:0] cur_cnt_i,
  input  logic [REG_W-1:0] base_addr_i,
  input  logic [REG_W-1:0] base_cnt_i,
  input  logic [UW-1:0]    units_i,
  input  logic             reload_i,
  output logic [REG_W-1:0] addr_o,
  output logic [REG_W-1:0] cnt_o
);

  logic [REG_W-1:0] moved;
  logic             unused_top;

  assign moved      = units_i[REG_W-1:0];
  assign unused_top = units_i[UW-1];

  always_comb begin
    if (reload_i) begin
      addr_o = base_addr_i;
      cnt_o  = base_cnt_i;
    end else begin
      addr_o = reg_step(cur_addr_i, moved, 1'b1);
      cnt_o  = reg_step(cur_cnt_i, moved, 1'b0);
    end
  end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int WORD_CH_MIN = 5,
  parameter int AVAIL_W     = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CH_W-1:0]    start_ch_i,
  input  logic               masked_i,
  input  logic               autoinit_i,
  input  logic [15:0]        cur_addr_i,
  input  logic [15:0]        cur_cnt_i,
  input  logic [15:0]        base_addr_i,
  input  logic [15:0]        base_cnt_i,
  input  logic [7:0]         page_i,
  input  logic [7:0]         page_hi_i,
  input  logic [AVAIL_W-1:0] avail_i,
  input  logic [AVAIL_W-1:0] offset_i,
  input  logic [AVAIL_W-1:0] bufsize_i,
  input  logic               mem_ready_i,
  output logic               mem_req_o,
  output logic [31:0]        mem_addr_o,
  output logic               mem_word_o,
  output logic               reg_wr_o,
  output logic [CH_W-1:0]    reg_ch_o,
  output logic [15:0]        reg_addr_o,
  output logic [15:0]        reg_cnt_o,
  output logic               done_o,
  output logic               err_o,
  output logic               busy_o
);

  localparam int UW = REG_W + 1;

  function automatic logic word_of(input logic [CH_W-1:0] c);
    return int'(c) >= WORD_CH_MIN;
  endfunction

  eng_state_t state_q;

  logic [CH_W-1:0]    ch_q;
  logic               word_q, auto_q;
  logic [REG_W-1:0]   addr_q, cnt_q, base_addr_q, base_cnt_q;
  logic [PAGE_W-1:0]  page_q, hi_q;
  logic [AVAIL_W-1:0] avail_q, off_q, bsz_q;
  logic [UW-1:0]      units_q;
  logic [AVAIL_W-1:0] bytes_q;
  logic               short_q, more_q;

  // Named events for the checker
  logic               start_take, plan_ok, beat_fire, last_beat, block_end, chain;
  logic [UW-1:0]      p_units;
  logic [AVAIL_W-1:0] p_bytes;
  logic               p_short, p_more, p_oob;
  logic [REG_W-1:0]   bg_addr, wb_addr, wb_cnt;

  dma_blk_plan #(.REG_W(REG_W), .AVAIL_W(AVAIL_W)) u_plan (
    .word_i   (word_q),
    .cnt_i    (cnt_q),
    .avail_i  (avail_q),
    .offset_i (off_q),
    .bufsize_i(bsz_q),
    .units_o  (p_units),
    .bytes_o  (p_bytes),
    .short_o  (p_short),
    .more_o   (p_more),
    .oob_o    (p_oob)
  );

  assign start_take = (state_q == ST_IDLE) && start_i && !masked_i;
  assign plan_ok    = (state_q == ST_PLAN) && !p_oob;
  assign beat_fire  = (state_q == ST_BEAT) && mem_ready_i;
  assign block_end  = (state_q == ST_WBACK);
  assign chain      = more_q && auto_q;

  dma_beat_gen #(.AW(REG_W), .UW(UW)) u_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (plan_ok),
    .load_addr_i (addr_q),
    .load_units_i(p_units),
    .adv_i       (beat_fire),
    .addr_o      (bg_addr),
    .last_o      (last_beat)
  );

  dma_wback #(.UW(UW)) u_wb (
    .cur_addr_i (addr_q),
    .cur_cnt_i  (cnt_q),
    .base_addr_i(base_addr_q),
    .base_cnt_i (base_cnt_q),
    .units_i    (units_q),
    .reload_i   (!short_q && auto_q),
    .addr_o     (wb_addr),
    .cnt_o      (wb_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ch_q        <= '0;
      word_q      <= 1'b0;
      auto_q      <= 1'b0;
      addr_q      <= '0;
      cnt_q       <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      hi_q        <= '0;
      avail_q     <= '0;
      off_q       <= '0;
      bsz_q       <= '0;
      units_q     <= '0;
      bytes_q     <= '0;
      short_q     <= 1'b0;
      more_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_take) begin
          ch_q        <= start_ch_i;
          word_q      <= word_of(start_ch_i);
          auto_q      <= autoinit_i;
          addr_q      <= cur_addr_i;
          cnt_q       <= cur_cnt_i;
          base_addr_q <= base_addr_i;
          base_cnt_q  <= base_cnt_i;
          page_q      <= page_i;
          hi_q        <= page_hi_i;
          avail_q     <= avail_i;
          off_q       <= offset_i;
          bsz_q       <= bufsize_i;
          state_q     <= ST_PLAN;
        end
        ST_PLAN: begin
          if (p_oob) begin
            state_q <= ST_IDLE;
          end else begin
            units_q <= p_units;
            bytes_q <= p_bytes;
            short_q <= p_short;
            more_q  <= p_more;
            state_q <= (p_units == '0) ? ST_WBACK : ST_BEAT;
          end
        end
        ST_BEAT: if (beat_fire && last_beat) state_q <= ST_WBACK;
        ST_WBACK: begin
          if (chain) begin
            avail_q <= avail_q - bytes_q;
            off_q   <= off_q + bytes_q;
            addr_q  <= base_addr_q;
            cnt_q   <= base_cnt_q;
            state_q <= ST_PLAN;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_BEAT);
  assign mem_addr_o = phys_addr(word_q, bg_addr, page_q, hi_q);
  assign mem_word_o = word_q;
  assign reg_wr_o   = block_end;
  assign reg_ch_o   = ch_q;
  assign reg_addr_o = wb_addr;
  assign reg_cnt_o  = wb_cnt;
  assign done_o     = block_end && !chain;
  assign err_o      = (state_q == ST_PLAN) && p_oob;
  assign busy_o     = (state_q != ST_IDLE);

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        masked_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_addr_o,
  input logic        reg_wr_o,
  input logic        done_o,
  input logic        err_o,
  input logic        beat_fire,
  input logic        last_beat
);

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  last_beat_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && last_beat |=> reg_wr_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_req_o && !reg_wr_o && !done_o);

  // R10
  mask_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && masked_i && !busy_o |=> !busy_o);

  // R4
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o && !mem_req_o);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .masked_i   (masked_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .reg_wr_o   (reg_wr_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .beat_fire  (beat_fire),
  .last_beat  (last_beat)
);

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int AVW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, masked_i = 0, autoinit_i = 0, mem_ready_i = 1;
  logic [2:0] start_ch_i = 0;
  logic [15:0] cur_addr_i = 0, cur_cnt_i = 0, base_addr_i = 0, base_cnt_i = 0;
  logic [7:0] page_i = 0, page_hi_i = 0;
  logic [AVW-1:0] avail_i = 0, offset_i = 0, bufsize_i = 0;
  logic mem_req_o, mem_word_o, reg_wr_o, done_o, err_o, busy_o;
  logic [31:0] mem_addr_o;
  logic [2:0] reg_ch_o;
  logic [15:0] reg_addr_o, reg_cnt_o;

  dma_xfer_engine #(.AVAIL_W(AVW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam int K_BEAT = 0, K_WR = 1, K_DONE = 2, K_ERR = 3;
  typedef struct { int kind; logic [63:0] val; string tag; } ev_t;
  ev_t exp_q[$];

  int checks = 0, fails = 0;
  int ncyc = 0, last_beat_cyc = -10;
  bit gap_chk = 0, stall_mode = 0, finished = 0;

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic observe(int kind, logic [63:0] val);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fail_line("R10", "unexpected event", 64'(kind), 64'hFFFF);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind || e.val != val)
      fail_line(e.tag, "event", {62'(kind), 2'b0} ^ val, {62'(e.kind), 2'b0} ^ e.val);
  endtask

  // Monitor: settled outputs at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (mem_req_o && mem_ready_i) begin
        observe(K_BEAT, {32'h0, mem_addr_o});
        last_beat_cyc = ncyc;
      end
      if (reg_wr_o) observe(K_WR, {29'h0, reg_ch_o, reg_addr_o, reg_cnt_o});
      if (done_o) begin
        observe(K_DONE, 64'h0);
        if (gap_chk) begin
          checks++;
          if (ncyc != last_beat_cyc + 1)
            fail_line("R9", "done gap", 64'(ncyc - last_beat_cyc), 64'd1);
        end
      end
      if (err_o) observe(K_ERR, 64'h0);
    end
  end

  // Ready pattern
  int rcnt = 0;
  always @(posedge clk) begin
    #1;
    rcnt++;
    mem_ready_i = stall_mode ? (rcnt % 3 == 0) : 1'b1;
  end

  // Reference model: expected event stream
  task automatic predict(string tag, int ch, int ca, int cc, int ba, int bc,
                         int pg, int hi, bit au, int av, int off, int bsz);
    int usz, want, want_b, n, nb;
    bit shrt;
    usz = (ch >= 5) ? 2 : 1;
    gap_chk = 0;
    forever begin
      want   = (cc & 16'hFFFF) + 1;
      want_b = want * usz;
      shrt   = av < want_b;
      n      = shrt ? av / usz : want;
      nb     = n * usz;
      if (off + nb > bsz) begin
        exp_q.push_back('{K_ERR, 64'h0, tag});
        gap_chk = 0;
        break;
      end
      for (int k = 0; k < n; k++) begin
        int a, pa;
        a  = (ca + k) & 16'hFFFF;
        pa = (usz == 2) ? ((a * 2) & 16'hFFFF) : a;
        exp_q.push_back('{K_BEAT, 64'((hi << 24) | (pg << 16) | pa), tag});
      end
      begin
        int na, nc;
        if (!shrt && au) begin na = ba; nc = bc; end
        else begin na = (ca + n) & 16'hFFFF; nc = (cc - n) & 16'hFFFF; end
        exp_q.push_back('{K_WR, {29'h0, 3'(ch), 16'(na), 16'(nc)}, tag});
      end
      if (av > want_b && au) begin
        av -= nb; off += nb; ca = ba; cc = bc;
      end else begin
        exp_q.push_back('{K_DONE, 64'h0, tag});
        gap_chk = (n > 0);
        break;
      end
    end
  endtask

  // Driver
  task automatic run_xfer(string tag, int ch, int ca, int cc, int ba, int bc,
                          int pg, int hi, bit au, int av, int off, int bsz, bit msk);
    if (!msk) predict(tag, ch, ca, cc, ba, bc, pg, hi, au, av, off, bsz);
    @(posedge clk); #2;
    start_ch_i = 3'(ch); cur_addr_i = 16'(ca); cur_cnt_i = 16'(cc);
    base_addr_i = 16'(ba); base_cnt_i = 16'(bc); page_i = 8'(pg); page_hi_i = 8'(hi);
    autoinit_i = au; avail_i = AVW'(av); offset_i = AVW'(off); bufsize_i = AVW'(bsz);
    masked_i = msk; start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0; masked_i = 1'b0;
    if (msk) begin
      repeat (10) begin
        @(negedge clk);
        checks++;
        if (busy_o) fail_line(tag, "busy after masked start", 64'(busy_o), 64'd0);
      end
    end else begin
      do @(negedge clk); while (!(done_o || err_o));
    end
    @(negedge clk); @(negedge clk);
    checks++;
    if (exp_q.size() != 0) fail_line(tag, "missing events", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (mem_req_o || reg_wr_o || done_o || err_o || busy_o)
      fail_line("R11", "reset outputs",
                64'({mem_req_o, reg_wr_o, done_o, err_o, busy_o}), 64'd0);
    rst_n = 1'b1;

    // R2/R4: byte channel, full block, count wraps to FFFF
    run_xfer("R2_R4 byte full", 1, 'h0300, 3, 0, 0, 'h05, 'h00, 0, 10, 0, 100, 0);
    // R1: word channel, shifted address wraps in 16 bits, pages on top
    run_xfer("R1 word addr", 5, 'h8002, 2, 0, 0, 'h12, 'h34, 0, 6, 0, 100, 0);
    // R1: byte address wraps modulo 2^16
    run_xfer("R1 byte wrap", 2, 'hFFFE, 3, 0, 0, 'h01, 'h02, 0, 4, 0, 100, 0);
    // R3: short byte block, autoinit suppressed
    run_xfer("R3 short byte", 2, 'h0050, 7, 'h0900, 9, 'h00, 'h00, 1, 5, 0, 100, 0);
    // R3: short word block, odd available count
    run_xfer("R3 short word", 6, 'h0100, 3, 0, 0, 'hAA, 'h00, 0, 5, 0, 100, 0);
    // R3: zero-unit block still writes back
    run_xfer("R3 zero units", 7, 'h0200, 0, 0, 0, 'h00, 'h00, 0, 1, 0, 100, 0);
    // R5: complete block with autoinit reloads base
    run_xfer("R5 reload", 3, 'h0010, 1, 'h0100, 3, 'h07, 'h00, 1, 2, 0, 100, 0);
    // R6: chained blocks until bytes run out
    run_xfer("R6 chain", 0, 'h0040, 1, 'h0200, 2, 'h03, 'h00, 1, 9, 0, 100, 0);
    // R7: first block out of bounds
    run_xfer("R7 oob first", 1, 'h0000, 3, 0, 0, 'h00, 'h00, 0, 10, 8, 10, 0);
    // R7: second block out of bounds after a write-back
    run_xfer("R7 oob chain", 0, 'h0040, 1, 'h0080, 3, 'h00, 'h00, 1, 10, 0, 5, 0);
    // R10: masked start ignored
    run_xfer("R10 masked", 1, 'h0000, 3, 0, 0, 'h00, 'h00, 0, 10, 0, 100, 1);
    // R8: stalling ready, beats in order and held
    stall_mode = 1;
    run_xfer("R8 stall byte", 1, 'h0700, 4, 0, 0, 'h09, 'h01, 0, 5, 0, 100, 0);
    run_xfer("R8 stall word chain", 5, 'h0001, 0, 'h0010, 1, 'h02, 'h00, 1, 6, 0, 100, 0);
    stall_mode = 0;

    finish_run();
  end

endmodule